// File: doc/BRIEF.md
# SPI Port with Master-Loss Fallback

This block is a byte-wide SPI controller for a system bus. The same logic acts as a bus master, driving the serial clock and the outgoing data line, or as a slave, which follows an external clock and answers on the return data line. Software reaches three byte registers through a simple write strobe and a combinational read port: control, status and data. In master mode, a write to the data register starts an 8-bit exchange. In slave mode, the same write preloads the byte that is returned to the next external master.

The chip-select input has two uses. For a slave, it gates participation in a frame. For a master, a low level means another device has taken the bus. The master then hands over: the bit that enables master operation is cleared by hardware, the completion flag is raised and the outputs are released. Two peers can therefore both idle as masters, and whichever pulls the other's select low wins. A control bit makes the select input irrelevant: the role then comes from the master bit alone, and a slave counts as always selected.

All pin inputs are assumed to be already synchronous to `clk`. The output-enable signals drive the pads, which are tri-stated outside the block.

Top module: `spi_port`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the control register (address 0), status register (address 1) and data register (address 2) all read 0. All three output enables are low and `sclk_o` is low.
- R2: With control bit0 (enable) and bit1 (master) set, a write to address 2 while idle exchanges one 8-bit frame. `sclk_o` makes exactly 16 transitions, each half-period lasts (2 << control[7:6]) clocks, and afterwards address 2 reads the byte received on `miso_i`.
- R3: Control bit3 chooses the bit order on the wire: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R4: Control bit4 is the idle level of the serial clock. Control bit5 selects the sampling edge: 0 samples on the first edge of each bit and changes data on the second, 1 changes data on the first edge and samples on the second.
- R5: Status bit7 is set at the end of every frame, as master or slave. Writing a 1 to status bit7 clears it, and writing a 0 there leaves it unchanged.
- R6: When enabled as master with control bit2 clear and `ss_n_i` low, the block clears control bit1, sets status bit7, abandons any frame in progress and drops `sclk_oe` and `mosi_oe` on the next cycle.
- R7: As an enabled slave with control bit2 clear, the block takes part only while `ss_n_i` is low. `miso_oe` is high only then.
- R8: With control bit2 set, `ss_n_i` has no effect: a master stays master with status unchanged while `ss_n_i` is low, and a slave responds while `ss_n_i` is high.
- R9: A slave frame that is cut short by `ss_n_i` rising is discarded without setting status bit7, and the next frame is received from its first bit.
- R10: A write to address 2 during a frame sets status bit6 and does not alter the frame in progress. Writing a 1 to status bit6 clears it.
- R11: With control bit0 clear, no output enable is raised, a low `ss_n_i` changes nothing and a data write starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ss_n_i | input | 1 | Active-low select input |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Enable for `sclk_o` |
| mosi_i | input | 1 | Data from an external master |
| mosi_o | output | 1 | Data sent as master |
| mosi_oe | output | 1 | Enable for `mosi_o` |
| miso_i | input | 1 | Data returned by a slave |
| miso_o | output | 1 | Data returned as slave |
| miso_oe | output | 1 | Enable for `miso_o` |

## Verification
Frames are exchanged in both roles across random bytes, both bit orders, all four clock polarity and phase pairs, and several divider settings. Comparing captured wire sequences with bit-reversed expectations separates an ordering fault from a sampling-edge fault, and measuring the half-period exposes divider errors. Directed cases cover what the random traffic does not reach: a select drop in the middle of a frame, a master demoted both idle and mid-frame, the ignore control in both roles, and a collision write. Each of these shows whether the block keeps or discards partial state.

// File: rtl/spi_port_pkg.sv
// Shared definitions for the SPI port: register layout and addresses.
package spi_port_pkg;

    // Control register fields; the packing order is the bit order software sees.
    typedef struct packed {
        logic [1:0] rate;       // half-period = 2 << rate system clocks
        logic       cpha;       // 1: sample on second edge of each bit
        logic       cpol;       // idle level of the serial clock
        logic       lsb_first;  // bit order on the wire
        logic       ss_ignore;  // select input has no effect when set
        logic       master;     // master role request
        logic       en;         // block enable
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_clkgen.sv
// Master serial clock generator. It produces 2*BITS half-periods of
// (BASE_HALF << rate) clocks after a start pulse and flags the leading and
// trailing edges of each bit. It assumes start arrives only while idle.
module spi_clkgen #(
    parameter int BITS      = 8,
    parameter int RATE_W    = 2,
    parameter int BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [RATE_W-1:0] rate,
    output logic              running,
    output logic              phase,
    output logic              lead,
    output logic              trail,
    output logic              done
);
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);
    localparam int DIVW  = $clog2(BASE_HALF << ((1 << RATE_W) - 1)) + 1;

    logic [DIVW-1:0] div_q;
    logic [EW-1:0]   edge_q;
    logic            run_q;
    logic            phase_q;
    logic [DIVW-1:0] half;
    logic            expire;

    assign half   = DIVW'(BASE_HALF) << rate;
    assign expire = run_q && (div_q == half - DIVW'(1));

    // Divider, edge counter and clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            div_q   <= '0;
            edge_q  <= '0;
        end else if (start && !run_q) begin
            run_q  <= 1'b1;
            div_q  <= '0;
            edge_q <= '0;
        end else if (expire) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
            edge_q  <= edge_q + EW'(1);
            if (edge_q == EW'(EDGES - 1)) run_q <= 1'b0;
        end else if (run_q) begin
            div_q <= div_q + DIVW'(1);
        end
    end

    assign running = run_q;
    assign phase   = phase_q;
    assign lead    = expire && !edge_q[0];
    assign trail   = expire && edge_q[0];
    assign done    = expire && (edge_q == EW'(EDGES - 1));

    // After the final edge the clock is parked at idle and the generator stops.
    assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!run_q && !phase_q));
    // An abort stops the clock at once.
    assert_abort_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!run_q && !phase_q));
endmodule

// File: rtl/spi_shifter.sv
// Shared shift register for both roles. It samples the input bit on sample
// pulses and updates the registered output bit on shift pulses. It assumes
// sample and shift never coincide.
module spi_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            clear,
    input  logic            sample,
    input  logic            shift,
    input  logic            in_bit,
    input  logic            lsb_first,
    output logic            out_bit,
    output logic [BITS-1:0] rx_data,
    output logic            frame_end,
    output logic            mid
);
    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] shreg;
    logic [BITS-1:0] rx_q;
    logic [BITS-1:0] shifted;
    logic [CW-1:0]   cnt;
    logic            out_q;

    assign shifted   = lsb_first ? {in_bit, shreg[BITS-1:1]} : {shreg[BITS-2:0], in_bit};
    assign frame_end = sample && !clear && !load && (cnt == CW'(BITS - 1));

    // Load, shift and frame-count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rx_q  <= '0;
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            shreg <= load_data;
            out_q <= lsb_first ? load_data[0] : load_data[BITS-1];
            cnt   <= '0;
        end else begin
            if (clear) begin
                cnt <= '0;
            end else if (sample) begin
                shreg <= shifted;
                cnt   <= frame_end ? '0 : cnt + CW'(1);
                if (frame_end) rx_q <= shifted;
            end
            if (shift) out_q <= lsb_first ? shreg[0] : shreg[BITS-1];
        end
    end

    assign out_bit = out_q;
    assign rx_data = rx_q;
    assign mid     = (cnt != '0);

    // A freshly loaded byte presents its first wire bit.
    assert_load_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_q == ($past(lsb_first) ? $past(load_data[0]) : $past(load_data[BITS-1]))));
    // A completed frame leaves no partial count behind.
    assert_frame_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !mid);
endmodule

// File: rtl/spi_port.sv
// SPI port top. It holds the register file and chooses the master clock or
// the detected external clock edges. It also handles the hand-over from
// master to slave when the select input is pulled low. It assumes all pin
// inputs are synchronous to clk.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int BITS      = 8,
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ss_n_i,
    input  logic       sclk_i,
    output logic       sclk_o,
    output logic       sclk_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe
);
    localparam int RATE_W = 2;

    ctrl_t     ctrl_q;
    logic      done_q, coll_q, sclk_q;
    logic      as_master, fault, selected, busy;
    logic      data_wr, accept, collide, start;
    logic      m_run, m_phase, m_lead, m_trail, m_done;
    logic      s_lead, s_trail, lead, trail;
    logic      sh_sample, sh_shift, sh_clear, sh_out, sh_end, sh_mid;
    logic [BITS-1:0] rx;

    assign as_master = ctrl_q.en && ctrl_q.master;
    assign fault     = as_master && !ctrl_q.ss_ignore && !ss_n_i;
    assign selected  = ctrl_q.en && !ctrl_q.master && (ctrl_q.ss_ignore || !ss_n_i);
    assign busy      = m_run || sh_mid;
    assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
    assign accept    = data_wr && !busy;
    assign collide   = data_wr && busy;
    assign start     = accept && as_master && !fault;

    // Slave edge detection, relative to the idle clock level.
    assign s_lead  = selected && (sclk_i != ctrl_q.cpol) && (sclk_q == ctrl_q.cpol);
    assign s_trail = selected && (sclk_i == ctrl_q.cpol) && (sclk_q != ctrl_q.cpol);
    assign lead      = as_master ? m_lead  : s_lead;
    assign trail     = as_master ? m_trail : s_trail;
    assign sh_sample = ctrl_q.cpha ? trail : lead;
    assign sh_shift  = ctrl_q.cpha ? lead  : trail;
    assign sh_clear  = fault || (!as_master && !selected);

    spi_clkgen #(.BITS(BITS), .RATE_W(RATE_W), .BASE_HALF(BASE_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(fault || !as_master),
        .rate(ctrl_q.rate), .running(m_run), .phase(m_phase),
        .lead(m_lead), .trail(m_trail), .done(m_done)
    );

    spi_shifter #(.BITS(BITS)) u_sh (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_data(reg_wdata[BITS-1:0]),
        .clear(sh_clear), .sample(sh_sample), .shift(sh_shift),
        .in_bit(as_master ? miso_i : mosi_i), .lsb_first(ctrl_q.lsb_first),
        .out_bit(sh_out), .rx_data(rx), .frame_end(sh_end), .mid(sh_mid)
    );

    // Control register, sticky flags and the previous external clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
            coll_q <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
            if (fault) ctrl_q.master <= 1'b0;
            if (m_done || fault || (sh_end && !as_master)) done_q <= 1'b1;
            else if (reg_wr && reg_addr == ADDR_STAT && reg_wdata[7]) done_q <= 1'b0;
            if (collide) coll_q <= 1'b1;
            else if (reg_wr && reg_addr == ADDR_STAT && reg_wdata[6]) coll_q <= 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: reg_rdata = {done_q, coll_q, 6'b0};
            ADDR_DATA: reg_rdata = 8'(rx);
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign sclk_o  = ctrl_q.cpol ^ m_phase;
    assign sclk_oe = as_master;
    assign mosi_o  = sh_out;
    assign mosi_oe = as_master;
    assign miso_o  = sh_out;
    assign miso_oe = selected;

    // Losing the bus demotes the master and raises the completion flag.
    assert_fault_demotes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!ctrl_q.master && done_q && !sclk_oe));
    // The completion flag rises only on a frame end or a hand-over.
    assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(m_done) || $past(sh_end) || $past(fault)));
    // A deselected slave never drives the return line.
    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ss_ignore && ss_n_i) |-> !miso_oe);
    // A write during a frame raises the collision flag.
    assert_collision_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> coll_q);
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [1:0] addr = 2'd1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic ss_n = 1'b1, sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
    logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;
    localparam int HB = 3;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .ss_n_i(ss_n), .sclk_i(sclk_i), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
    endfunction

    function automatic logic wire_bit(input logic [7:0] v, input int i, input logic lsb);
        return lsb ? v[i] : v[7 - i];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = 2'd1;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata; addr = 2'd1;
    endtask

    // The bench acts as a slave while the design is master.
    task automatic run_master(input logic [7:0] tx, input logic [7:0] stx, input logic lsb,
                              input logic cpol, input logic cpha, input logic [1:0] rate,
                              input bit coll);
        logic [7:0] seq = 8'h00, v;
        logic prev, cur, is_lead;
        int edges = 0, t1 = 0, hp = 0, pos = 0;
        bit done = 1'b0, injected = 1'b0;
        ss_n = 1'b1;
        reg_write(2'd0, {rate, cpha, cpol, lsb, 1'b0, 1'b1, 1'b1});
        reg_write(2'd1, 8'hC0);
        @(negedge clk);
        chk("R4", "idle clock level", sclk_o, cpol);
        chk("R2", "master enables", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        miso_i = cpha ? 1'b0 : wire_bit(stx, 0, lsb);
        prev = cpol;
        wr = 1'b1; addr = 2'd2; wdata = tx;
        @(negedge clk); wr = 1'b0; addr = 2'd1;
        for (int k = 0; k < 800 && !done; k++) begin
            cur = sclk_o;
            if (cur != prev) begin
                edges++;
                if (edges == 1) t1 = cyc;
                if (edges == 2) hp = cyc - t1;
                is_lead = (prev == cpol);
                if (cpha ? !is_lead : is_lead) seq = {seq[6:0], mosi_o};
                if (!cpha && !is_lead) begin
                    pos++;
                    if (pos < 8) miso_i = wire_bit(stx, pos, lsb);
                end
                if (cpha && is_lead) begin
                    miso_i = wire_bit(stx, pos, lsb);
                    pos++;
                end
                prev = cur;
            end
            if (coll && edges == 4 && !injected) begin
                wr = 1'b1; addr = 2'd2; wdata = ~tx; injected = 1'b1;
            end else if (wr) begin
                wr = 1'b0; addr = 2'd1;
            end
            #1;
            if (!wr && rdata[7]) done = 1'b1;
            @(negedge clk);
        end
        wr = 1'b0; addr = 2'd1;
        chk("R5", "done flag after master frame", done, 1);
        chk("R2", "clock edge count", edges, 16);
        chk("R2", "half period", hp, 2 << rate);
        chk("R3", "bits on mosi in wire order", seq, lsb ? rev8(tx) : tx);
        chk("R4", "clock parked at idle", sclk_o, cpol);
        reg_read(2'd2, v);
        chk("R2", "received byte", v, stx);
        if (coll) begin
            reg_read(2'd1, v);
            chk("R10", "collision flag", v[6], 1);
            reg_write(2'd1, 8'h40);
            reg_read(2'd1, v);
            chk("R10", "collision flag cleared", v[6], 0);
        end
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v);
        chk("R5", "write 0 keeps flag", v[7], 1);
        reg_write(2'd1, 8'h80);
        reg_read(2'd1, v);
        chk("R5", "flag cleared by write 1", v[7], 0);
    endtask

    // The bench acts as a master clocking nbits into the design.
    task automatic clock_bits(input logic [7:0] mtx, input int nbits, input logic lsb,
                              input logic cpol, input logic cpha, output logic [7:0] seq);
        seq = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi_i = wire_bit(mtx, i, lsb);
                repeat (HB) @(negedge clk);
                sclk_i = ~cpol; seq = {seq[6:0], miso_o};
                repeat (HB) @(negedge clk);
                sclk_i = cpol;
            end else begin
                repeat (HB) @(negedge clk);
                sclk_i = ~cpol; mosi_i = wire_bit(mtx, i, lsb);
                repeat (HB) @(negedge clk);
                sclk_i = cpol; seq = {seq[6:0], miso_o};
            end
        end
    endtask

    task automatic run_slave(input logic [7:0] stx, input logic [7:0] mtx, input logic lsb,
                             input logic cpol, input logic cpha, input logic ign,
                             input logic ss_level);
        logic [7:0] seq, v;
        ss_n = 1'b1; sclk_i = cpol;
        reg_write(2'd0, {2'b00, cpha, cpol, lsb, ign, 1'b0, 1'b1});
        reg_write(2'd1, 8'hC0);
        reg_write(2'd2, stx);
        @(negedge clk); ss_n = ss_level;
        repeat (2) @(negedge clk);
        chk(ign ? "R8" : "R7", "slave drives miso when selected", miso_oe, 1);
        clock_bits(mtx, 8, lsb, cpol, cpha, seq);
        repeat (3) @(negedge clk);
        chk(ign ? "R8" : "R7", "bits on miso in wire order", seq, lsb ? rev8(stx) : stx);
        reg_read(2'd1, v);
        chk("R5", "done flag after slave frame", v[7], 1);
        reg_read(2'd2, v);
        chk(ign ? "R8" : "R7", "slave received byte", v, mtx);
        ss_n = 1'b1;
        @(negedge clk);
        chk(ign ? "R8" : "R7", "miso enable after select released", miso_oe, ign);
        reg_write(2'd1, 8'h80);
    endtask

    initial begin
        logic [7:0] v, seq;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read(2'd0, v); chk("R1", "control after reset", v, 0);
        reg_read(2'd1, v); chk("R1", "status after reset", v, 0);
        reg_read(2'd2, v); chk("R1", "data after reset", v, 0);
        chk("R1", "enables and clock after reset", {sclk_oe, mosi_oe, miso_oe, sclk_o}, 0);

        // R11 disabled block ignores select and data writes
        reg_write(2'd0, 8'h02);
        ss_n = 1'b0;
        reg_write(2'd2, 8'h33);
        repeat (40) @(negedge clk);
        reg_read(2'd0, v); chk("R11", "control unchanged while disabled", v, 8'h02);
        reg_read(2'd1, v); chk("R11", "no flag while disabled", v, 0);
        chk("R11", "no enables while disabled", {sclk_oe, mosi_oe, miso_oe, sclk_o}, 0);
        ss_n = 1'b1;

        // R2 R3 R4 directed corners, then random traffic
        run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        run_master(8'h01, 8'h80, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0);
        for (int n = 0; n < 8; n++)
            run_master(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 2'($urandom_range(0, 2)), 1'b0);
        // R10 collision during a master frame
        run_master(8'hC3, 8'h5A, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1);

        // R7 slave frames, directed then random
        run_slave(8'h96, 8'h69, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int n = 0; n < 8; n++)
            run_slave(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'b0, 1'b0);
        // R8 ignore bit: slave answers with select high
        run_slave(8'hE1, 8'h1E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

        // R9 slave frame cut short, then a full frame
        ss_n = 1'b1; sclk_i = 1'b0;
        reg_write(2'd0, 8'h01);
        reg_write(2'd1, 8'hC0);
        reg_write(2'd2, 8'h00);
        @(negedge clk); ss_n = 1'b0;
        clock_bits(8'hFF, 3, 1'b0, 1'b0, 1'b0, seq);
        repeat (2) @(negedge clk); ss_n = 1'b1;
        repeat (3) @(negedge clk);
        reg_read(2'd1, v); chk("R9", "no flag for abandoned frame", v[7], 0);
        run_slave(8'h11, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8 ignore bit keeps the master role with select low
        reg_write(2'd0, 8'h07);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(2'd0, v); chk("R8", "master kept with select low", v, 8'h07);
        reg_read(2'd1, v); chk("R8", "no flag with select ignored", v[7], 0);
        ss_n = 1'b1;

        // R6 idle master demoted by select low
        reg_write(2'd0, 8'h03);
        reg_write(2'd1, 8'hC0);
        @(negedge clk); ss_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R6", "outputs released", {sclk_oe, mosi_oe}, 0);
        chk("R6", "now a selected slave", miso_oe, 1);
        reg_read(2'd0, v); chk("R6", "master bit cleared", v, 8'h01);
        reg_read(2'd1, v); chk("R6", "flag set by hand-over", v[7], 1);
        ss_n = 1'b1;

        // R6 master demoted in the middle of a frame
        reg_write(2'd0, 8'hD3);
        reg_write(2'd1, 8'hC0);
        reg_write(2'd2, 8'h5A);
        repeat (20) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R6", "clock released mid-frame", sclk_oe, 0);
        chk("R6", "clock back at idle", sclk_o, 1);
        reg_read(2'd1, v); chk("R6", "flag set mid-frame", v[7], 1);
        reg_read(2'd0, v); chk("R6", "master bit cleared mid-frame", v[1], 0);
        ss_n = 1'b1;

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule